// File: doc/BRIEF.md
# TDM Quadrant LSB Signaling Forcer

This block sits on one serial time-division-multiplexed input stream. It tracks the bit and channel position inside each frame and, for chosen parts of the frame, overwrites bit 0 of every 8-bit channel with a 1 so that bit-robbed signaling can ride on the stream. Every other bit passes through untouched, and the output is the input delayed by one bit clock.

The frame is cut into four equal quadrants. Each quadrant has its own enable bit, and their channel ranges follow a two-bit rate select: 32, 64 or 128 channels per frame. Each stream gets its own instance, so each stream has its own enables. A frame pulse marks the frame start. The enables and the rate are captured at that pulse, so a frame is never only partly modified.

Top module: `tdm_quad_lsb_forcer`

## Requirements
- R1: A synchronous active-high reset drives `tx_bit_o` to 0 and clears the captured enables. Until the first frame pulse after reset, `tx_bit_o` equals `rx_bit_i` from one clock earlier, with no bit forced.
- R2: Every bit other than bit 0 of a channel appears on `tx_bit_o` exactly one clock after it was on `rx_bit_i`, unchanged.
- R3: Channels arrive MSB first. A 1 on `frame_pulse_i` sampled at a clock edge makes the next input bit bit 7 of channel 0. Bit 0 of a channel is its eighth bit.
- R4: When the captured enable `quad_en_i[q]` is 1, bit 0 of every channel in quadrant q leaves as 1. When it is 0, that bit leaves as it came in.
- R5: `rate_sel_i` = 2'b00 gives a 32-channel frame with quadrants 0..7, 8..15, 16..23 and 24..31.
- R6: `rate_sel_i` = 2'b01 gives a 64-channel frame with quadrants 0..15, 16..31, 32..47 and 48..63.
- R7: `rate_sel_i` = 2'b10 gives a 128-channel frame with quadrants 0..31, 32..63, 64..95 and 96..127.
- R8: `rate_sel_i` = 2'b11 is treated exactly as 2'b00.
- R9: `quad_en_i` and `rate_sel_i` are captured only at the clock edge where `frame_pulse_i` is 1. Changing them at any other time has no effect on the output until the next frame pulse.
- R10: Without a new frame pulse, the channel count wraps from the last channel of the frame back to channel 0 and forcing continues in step.
- R11: A frame pulse that arrives mid-frame realigns the counters at once: the next bit is taken as bit 7 of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse_i | input | 1 | Frame start marker, high one clock before channel 0 bit 7 |
| rx_bit_i | input | 1 | Serial input data |
| quad_en_i | input | 4 | Per-quadrant LSB force enables, bit q for quadrant q |
| rate_sel_i | input | 2 | Frame size select: 00=32, 01=64, 10=128, 11=32 channels |
| tx_bit_o | output | 1 | Serial output data, one clock behind the input |

## Verification
The bench uses the default parameters: 8-bit channels and a 32-channel base frame. Every frame length of the design therefore stays at 1024 bit clocks or fewer. This makes it cheap to sweep all four rate codes against all sixteen enable patterns, with full frames of random data, so every quadrant boundary at every rate is crossed under each enable combination. Separate runs cover the cycles before the first pulse, an enable change mid-frame, a frame that wraps with no pulse, and a pulse that lands mid-frame.

// File: rtl/tqf_pkg.sv
package tqf_pkg;

  typedef enum logic [1:0] {
    RATE_X1  = 2'b00,
    RATE_X2  = 2'b01,
    RATE_X4  = 2'b10,
    RATE_RSV = 2'b11
  } rate_e;

  // log2 of the frame size multiplier over the base channel count
  function automatic int unsigned rate_shift(rate_e r);
    case (r)
      RATE_X2: return 1;
      RATE_X4: return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tqf_cfg_latch.sv
module tqf_cfg_latch
  import tqf_pkg::*;
#(
  parameter int NUM_QUAD = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_pulse_i,
  input  logic [NUM_QUAD-1:0] quad_en_i,
  input  logic [1:0]          rate_sel_i,
  output logic [NUM_QUAD-1:0] en_q_o,
  output rate_e               rate_q_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q_o   <= '0;
      rate_q_o <= RATE_X1;
    end else if (frame_pulse_i) begin
      en_q_o   <= quad_en_i;
      rate_q_o <= rate_e'(rate_sel_i);
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_pulse_i |=> ($stable(en_q_o) && $stable(rate_q_o))); // R9

endmodule

// File: rtl/tqf_frame_counter.sv
module tqf_frame_counter
  import tqf_pkg::*;
#(
  parameter int BITS_PER_CH  = 8,
  parameter int BASE_CH_LOG2 = 5,
  localparam int BIT_W = $clog2(BITS_PER_CH),
  localparam int CH_W  = BASE_CH_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse_i,
  input  rate_e            rate_i,
  output logic             synced_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             last_bit_o
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_CH - 1);

  logic [CH_W-1:0] chan_last;

  always_comb begin
    chan_last  = CH_W'((1 << (BASE_CH_LOG2 + rate_shift(rate_i))) - 1);
    last_bit_o = synced_o && (bit_idx_o == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synced_o  <= 1'b0;
      bit_idx_o <= '0;
      chan_o    <= '0;
    end else if (frame_pulse_i) begin
      synced_o  <= 1'b1;
      bit_idx_o <= '0;
      chan_o    <= '0;
    end else if (synced_o) begin
      if (bit_idx_o == BIT_LAST) begin
        bit_idx_o <= '0;
        chan_o    <= (chan_o == chan_last) ? '0 : chan_o + 1'b1;
      end else begin
        bit_idx_o <= bit_idx_o + 1'b1;
      end
    end
  end

  AST_FP_ALIGN: assert property (@(posedge clk) disable iff (rst)
    frame_pulse_i |=> (synced_o && bit_idx_o == '0 && chan_o == '0)); // R3

  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!frame_pulse_i && last_bit_o) |=> (bit_idx_o == '0)); // R2

  AST_CHAN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!frame_pulse_i && last_bit_o && chan_o == chan_last) |=> (chan_o == '0)); // R10

endmodule

// File: rtl/tqf_quad_decode.sv
module tqf_quad_decode
  import tqf_pkg::*;
#(
  parameter int BASE_CH_LOG2 = 5,
  localparam int CH_W = BASE_CH_LOG2 + 2
) (
  input  logic [CH_W-1:0] chan_i,
  input  rate_e           rate_i,
  output logic [1:0]      quad_o
);

  logic [CH_W-1:0] shifted;

  always_comb begin
    shifted = chan_i >> (BASE_CH_LOG2 - 2 + rate_shift(rate_i));
    quad_o  = shifted[1:0];
  end

endmodule

// File: rtl/tdm_quad_lsb_forcer.sv
module tdm_quad_lsb_forcer
  import tqf_pkg::*;
#(
  parameter int BITS_PER_CH  = 8,
  parameter int BASE_CH_LOG2 = 5,
  localparam int NUM_QUAD = 4,
  localparam int BIT_W    = $clog2(BITS_PER_CH),
  localparam int CH_W     = BASE_CH_LOG2 + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_pulse_i,
  input  logic                rx_bit_i,
  input  logic [NUM_QUAD-1:0] quad_en_i,
  input  logic [1:0]          rate_sel_i,
  output logic                tx_bit_o
);

  logic [NUM_QUAD-1:0] en_q;
  rate_e               rate_q;
  logic                synced;
  logic [BIT_W-1:0]    bit_idx;
  logic [CH_W-1:0]     chan;
  logic                last_bit;
  logic [1:0]          quad;
  logic                force_c;

  tqf_cfg_latch #(.NUM_QUAD(NUM_QUAD)) cfg_i (
    .clk(clk), .rst(rst), .frame_pulse_i(frame_pulse_i),
    .quad_en_i(quad_en_i), .rate_sel_i(rate_sel_i),
    .en_q_o(en_q), .rate_q_o(rate_q)
  );

  tqf_frame_counter #(.BITS_PER_CH(BITS_PER_CH), .BASE_CH_LOG2(BASE_CH_LOG2)) cnt_i (
    .clk(clk), .rst(rst), .frame_pulse_i(frame_pulse_i), .rate_i(rate_q),
    .synced_o(synced), .bit_idx_o(bit_idx), .chan_o(chan), .last_bit_o(last_bit)
  );

  tqf_quad_decode #(.BASE_CH_LOG2(BASE_CH_LOG2)) dec_i (
    .chan_i(chan), .rate_i(rate_q), .quad_o(quad)
  );

  always_comb force_c = last_bit && en_q[quad];

  always_ff @(posedge clk) begin
    if (rst) tx_bit_o <= 1'b0;
    else     tx_bit_o <= rx_bit_i | force_c;
  end

  AST_PRESYNC_PASS: assert property (@(posedge clk) disable iff (rst)
    !synced |=> (tx_bit_o == $past(rx_bit_i))); // R1

  AST_NONLSB_PASS: assert property (@(posedge clk) disable iff (rst)
    (bit_idx != BIT_W'(BITS_PER_CH - 1)) |=> (tx_bit_o == $past(rx_bit_i))); // R2

  AST_LSB_FORCE: assert property (@(posedge clk) disable iff (rst)
    (synced && bit_idx == BIT_W'(BITS_PER_CH - 1) && en_q[quad]) |=> tx_bit_o); // R4

endmodule

// File: tb/tdm_quad_lsb_forcer_tb_top.sv
`timescale 1ns/1ps
module tdm_quad_lsb_forcer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_pulse = 1'b0;
  logic       rx = 1'b0;
  logic [3:0] q_en = 4'h0;
  logic [1:0] rate = 2'b00;
  logic       tx;

  int n_tests = 0;
  int n_fail  = 0;

  // bench-side position model built from the requirements
  bit       m_sync = 0;
  int       m_bit = 0;
  int       m_ch = 0;
  bit [3:0] m_en = 0;
  int       m_rate = 0;

  always #5 clk = ~clk;

  tdm_quad_lsb_forcer dut_i (
    .clk(clk), .rst(rst), .frame_pulse_i(frame_pulse), .rx_bit_i(rx),
    .quad_en_i(q_en), .rate_sel_i(rate), .tx_bit_o(tx)
  );

  function automatic int nch(int r);
    if (r == 1) return 64;
    if (r == 2) return 128;
    return 32;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // called at a falling edge; drives one bit and checks it one clock later
  task automatic step(input bit fp, input bit d, input string tag);
    logic exp;
    int   quad;
    frame_pulse = fp;
    rx = d;
    quad = m_ch / (nch(m_rate) / 4);
    exp = d | (m_sync && m_bit == 7 && m_en[quad]);
    if (fp) begin
      m_sync = 1; m_bit = 0; m_ch = 0; m_en = q_en; m_rate = int'(rate);
    end else if (m_sync) begin
      if (m_bit == 7) begin
        m_bit = 0;
        m_ch = (m_ch + 1) % nch(m_rate);
      end else m_bit++;
    end
    @(posedge clk); @(negedge clk);
    check(tx, exp, tag);
  endtask

  task automatic run_bits(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'($urandom_range(0, 1)), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rx = 1'b1;
    repeat (3) @(negedge clk);
    check(tx, 1'b0, "R1 reset value");
    rst = 1'b0;
    // R1: before any pulse, all bits pass, even with all enables set
    q_en = 4'hF;
    run_bits(40, "R1 pre-sync pass");

    // R3 R4 R5..R8 R2: full sweep of rate codes and enable patterns
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 16; e++) begin
        string tag;
        q_en = 4'(e);
        rate = 2'(r);
        tag = (r == 0) ? "R3 R4 R5 R2" : (r == 1) ? "R3 R4 R6 R2" :
              (r == 2) ? "R3 R4 R7 R2" : "R3 R4 R8 R2";
        step(1'b1, 1'($urandom_range(0, 1)), tag);
        run_bits(nch(r) * 8 - 1, tag);
      end
    end

    // R9: change enables and rate mid-frame; no effect until next pulse
    q_en = 4'b0101; rate = 2'b01;
    step(1'b1, 1'b0, "R9 setup");
    run_bits(200, "R9 before change");
    q_en = 4'b1010; rate = 2'b10;
    for (int i = 0; i < 64 * 8 - 201; i++) step(1'b0, 1'b0, "R9 mid-frame change ignored");
    step(1'b1, 1'b0, "R9 new pulse");
    run_bits(128 * 8 - 1, "R9 applied after pulse");

    // R10: frames keep running with no further pulse
    q_en = 4'b1001; rate = 2'b00;
    step(1'b1, 1'b0, "R10 setup");
    for (int i = 0; i < 3 * 32 * 8; i++) step(1'b0, 1'b0, "R10 wrap without pulse");

    // R11: pulse mid-frame realigns the counters
    q_en = 4'b0001; rate = 2'b01;
    step(1'b1, 1'b0, "R11 setup");
    run_bits(333, "R11 partial frame");
    q_en = 4'b0100; rate = 2'b00;
    step(1'b1, 1'b0, "R11 mid-frame pulse");
    for (int i = 0; i < 2 * 32 * 8; i++) step(1'b0, 1'b0, "R11 realigned");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule